// File: doc/BRIEF.md
# Dimension-Order Route Selector for a 2-D Mesh Switch

This block is the route-computation stage of one switch in a two-dimensional mesh. When a packet header is presented, it subtracts the switch's own position from the destination position in each dimension. It then names the single output port the packet must take next. The X dimension is always finished before any Y hop is taken. A packet that has reached its destination in both dimensions is sent to the local ejection port.

The choice is registered. It appears one cycle after the header strobe and stays on the outputs until the next strobe. Destinations that lie outside the mesh raise an error flag and select no port. The crossbar, buffers, input arbitration and virtual channels sit outside this block.

Top module: `dor_route_unit`

## Requirements
- R1: While reset is held and after it is released, before any header strobe, `port_sel` is 0 and `sel_valid` and `route_err` are 0.
- R2: `sel_valid` is 1 in exactly the cycle after a cycle in which `hdr_valid` was 1. Otherwise it is 0.
- R3: If the destination X differs from the node X, `port_sel` is bit 1 (plus-X) when the destination X is larger. It is bit 2 (minus-X) when the destination X is smaller. This holds whatever the Y fields are.
- R4: If the X coordinates are equal and the Y coordinates differ, `port_sel` is bit 3 (plus-Y) when the destination Y is larger. It is bit 4 (minus-Y) when the destination Y is smaller.
- R5: If both coordinates are equal, `port_sel` is bit 0 (local ejection).
- R6: `port_sel` has exactly one bit set when `route_err` is 0, and no bit set when `route_err` is 1.
- R7: A destination with X of MESH_X or more, or Y of MESH_Y or more, gives `route_err` = 1 and `port_sel` = 0. The defaults are a 5 by 4 mesh.
- R8: `port_sel` and `route_err` keep their values in every cycle that follows a cycle without `hdr_valid`. Field changes without the strobe have no effect.
- R9: No port leading off the mesh is chosen. Plus-X is never chosen at X = MESH_X-1, and minus-X is never chosen at X = 0. The same rule holds for Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Header fields are valid this cycle |
| dest_x | input | COORD_W | Destination X coordinate from the header |
| dest_y | input | COORD_W | Destination Y coordinate from the header |
| node_x | input | COORD_W | This switch's X coordinate |
| node_y | input | COORD_W | This switch's Y coordinate |
| port_sel | output | 5 | One-hot port choice: 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y |
| sel_valid | output | 1 | Pulses one cycle after `hdr_valid` |
| route_err | output | 1 | Destination lies outside the mesh |

## Verification
The hardest case to reach is a switch on the mesh edge receiving a header whose destination lies just beyond that edge. This case separates the range error from an ordinary off-mesh hop, and uniformly random headers rarely produce it. The stimulus therefore places the node on each border and corner by directed cases. It also draws random destinations from a range wider than the mesh, so out-of-range values in either dimension occur often. Between strobes, the bench scrambles the header fields to show that the held decision does not move.

// File: rtl/dor_pkg.sv
// Shared port encoding for the dimension-order route selector.
// Assumes a five-port switch: local ejection plus four mesh neighbours.
package dor_pkg;
    localparam int PORT_N  = 5;
    localparam int P_LOCAL = 0;
    localparam int P_XPOS  = 1;
    localparam int P_XNEG  = 2;
    localparam int P_YPOS  = 3;
    localparam int P_YNEG  = 4;

    typedef logic [PORT_N-1:0] port_vec_t;

    // Direction of travel in one dimension.
    typedef struct packed {
        logic pos;   // destination ahead of node
        logic neg;   // destination behind node
        logic oob;   // destination outside the mesh in this dimension
    } dim_dir_t;
endpackage

// File: rtl/dor_axis_offset.sv
// Per-dimension offset unit: forms the signed offset destination minus node
// and classifies it as ahead, behind or equal; also flags a destination past
// the last row/column. Assumes the node coordinate itself lies inside the mesh.
module dor_axis_offset #(
    parameter int COORD_W = 4,
    parameter int RADIX   = 5
) (
    input  logic [COORD_W-1:0] dest_c,
    input  logic [COORD_W-1:0] node_c,
    output dor_pkg::dim_dir_t  dir
);
    localparam int OFS_W = COORD_W + 1;
    localparam logic [COORD_W-1:0] LAST = COORD_W'(RADIX - 1);

    logic signed [OFS_W-1:0] ofs;

    // Signed relative offset and its classification.
    always_comb begin
        ofs     = $signed({1'b0, dest_c}) - $signed({1'b0, node_c});
        dir.neg = ofs[OFS_W-1];
        dir.pos = !ofs[OFS_W-1] && (ofs != '0);
        dir.oob = (dest_c > LAST);
    end
endmodule

// File: rtl/dor_port_pick.sv
// Port picker: applies strict X-then-Y order to the two dimension results.
// Assumes at most one of pos/neg is set per dimension.
module dor_port_pick (
    input  dor_pkg::dim_dir_t xdir,
    input  dor_pkg::dim_dir_t ydir,
    output dor_pkg::port_vec_t port,
    output logic              err
);
    import dor_pkg::*;

    // X resolved first, then Y, then ejection; out-of-mesh selects nothing.
    always_comb begin
        port = '0;
        err  = xdir.oob || ydir.oob;
        if (!err) begin
            if (xdir.pos)      port[P_XPOS]  = 1'b1;
            else if (xdir.neg) port[P_XNEG]  = 1'b1;
            else if (ydir.pos) port[P_YPOS]  = 1'b1;
            else if (ydir.neg) port[P_YNEG]  = 1'b1;
            else               port[P_LOCAL] = 1'b1;
        end
    end
endmodule

// File: rtl/dor_route_unit.sv
// Top of the dimension-order route selector. Computes the output port for a
// header in the cycle hdr_valid is high and registers it; the decision holds
// until the next header. Assumes node_x/node_y are static and inside the mesh.
module dor_route_unit #(
    parameter int COORD_W = 4,
    parameter int MESH_X  = 5,
    parameter int MESH_Y  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] node_x,
    input  logic [COORD_W-1:0] node_y,
    output logic [4:0]         port_sel,
    output logic               sel_valid,
    output logic               route_err
);
    import dor_pkg::*;

    localparam int DIMS = 2;

    dim_dir_t  dir [DIMS];
    port_vec_t port_nxt;
    logic      err_nxt;

    // One offset unit per dimension; index 0 is X, index 1 is Y.
    for (genvar d = 0; d < DIMS; d++) begin : g_dim
        localparam int RAD = (d == 0) ? MESH_X : MESH_Y;
        dor_axis_offset #(.COORD_W(COORD_W), .RADIX(RAD)) u_ofs (
            .dest_c (d == 0 ? dest_x : dest_y),
            .node_c (d == 0 ? node_x : node_y),
            .dir    (dir[d])
        );
    end

    dor_port_pick u_pick (
        .xdir (dir[0]),
        .ydir (dir[1]),
        .port (port_nxt),
        .err  (err_nxt)
    );

    // Capture the decision on a header strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_sel  <= '0;
            route_err <= 1'b0;
            sel_valid <= 1'b0;
        end else begin
            sel_valid <= hdr_valid;
            if (hdr_valid) begin
                port_sel  <= port_nxt;
                route_err <= err_nxt;
            end
        end
    end
endmodule

// File: rtl/dor_route_chk.sv
// Assertion checker for dor_route_unit, attached with bind below.
module dor_route_chk #(
    parameter int COORD_W = 4,
    parameter int MESH_X  = 5,
    parameter int MESH_Y  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hdr_valid,
    input logic [COORD_W-1:0] dest_x,
    input logic [COORD_W-1:0] dest_y,
    input logic [COORD_W-1:0] node_x,
    input logic [COORD_W-1:0] node_y,
    input logic [4:0]         port_sel,
    input logic               sel_valid,
    input logic               route_err
);
    localparam logic [COORD_W-1:0] LX = COORD_W'(MESH_X - 1);
    localparam logic [COORD_W-1:0] LY = COORD_W'(MESH_Y - 1);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> sel_valid);
    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !sel_valid);
    assert_x_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && dest_x > node_x && dest_x <= LX && dest_y <= LY) |=> port_sel[1]);
    assert_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && dest_x == node_x && dest_y == node_y && dest_x <= LX && dest_y <= LY)
        |=> port_sel[0]);
    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        route_err ? (port_sel == '0) : ($countones(port_sel) == 1 || !$past(rst_n) || port_sel == '0));
    assert_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (dest_x > LX || dest_y > LY)) |=> (route_err && port_sel == '0));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> ($stable(port_sel) && $stable(route_err)));
    assert_no_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> !((port_sel[1] && $past(node_x) == LX) || (port_sel[2] && $past(node_x) == '0)
                      || (port_sel[3] && $past(node_y) == LY) || (port_sel[4] && $past(node_y) == '0)));
endmodule

bind dor_route_unit dor_route_chk #(.COORD_W(COORD_W), .MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_chk (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .dest_x(dest_x), .dest_y(dest_y),
    .node_x(node_x), .node_y(node_y), .port_sel(port_sel), .sel_valid(sel_valid),
    .route_err(route_err)
);

// File: tb/tb_dor_route_unit.sv
// Bench for dor_route_unit: directed edge cases plus seeded random headers.
module tb_dor_route_unit;
    localparam int W  = 4;
    localparam int MX = 5;
    localparam int MY = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic [W-1:0] dest_x = '0, dest_y = '0, node_x = '0, node_y = '0;
    logic [4:0]   port_sel;
    logic         sel_valid, route_err;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    dor_route_unit #(.COORD_W(W), .MESH_X(MX), .MESH_Y(MY)) dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .dest_x(dest_x), .dest_y(dest_y),
        .node_x(node_x), .node_y(node_y), .port_sel(port_sel), .sel_valid(sel_valid),
        .route_err(route_err)
    );

    // Expected one-hot port, zero on an out-of-mesh destination.
    function automatic logic [4:0] exp_port(int nx, int ny, int dx, int dy);
        if (dx >= MX || dy >= MY) return 5'b00000;
        if (dx > nx) return 5'b00010;
        if (dx < nx) return 5'b00100;
        if (dy > ny) return 5'b01000;
        if (dy < ny) return 5'b10000;
        return 5'b00001;
    endfunction

    function automatic logic exp_err(int dx, int dy);
        return (dx >= MX || dy >= MY);
    endfunction

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one header, check the result, then scramble fields without a strobe.
    task automatic route(int nx, int ny, int dx, int dy);
        logic [4:0] ep;
        logic       ee;
        string      tag;
        ep = exp_port(nx, ny, dx, dy);
        ee = exp_err(dx, dy);
        if (ee)            tag = "R7";
        else if (dx != nx) tag = "R3";
        else if (dy != ny) tag = "R4";
        else               tag = "R5";
        @(negedge clk);
        node_x = W'(nx); node_y = W'(ny); dest_x = W'(dx); dest_y = W'(dy);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R2 valid pulse", {5'b0, sel_valid}, 6'd1);
        check(tag, {port_sel, route_err}, {ep, ee});
        check("R6 onehot", {5'b0, ee ? (port_sel == 0) : ($countones(port_sel) == 1)}, 6'd1);
        dest_x = W'($urandom % 16); dest_y = W'($urandom % 16);
        @(negedge clk);
        check("R2 valid drop", {5'b0, sel_valid}, 6'd0);
        check("R8 hold", {port_sel, route_err}, {ep, ee});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset", {port_sel, route_err}, 6'd0);
        check("R1 reset valid", {5'b0, sel_valid}, 6'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {port_sel, route_err, sel_valid}, 7'd0);
        // Directed corners (R9 edges, R7 just past edges).
        route(0, 0, 0, 0);
        route(4, 3, 0, 0);
        route(0, 0, 4, 3);
        route(2, 2, 2, 0);
        route(2, 1, 2, 3);
        route(4, 0, 4, 3);
        route(0, 3, 0, 0);
        route(4, 3, 5, 3);
        route(4, 3, 4, 4);
        route(0, 0, 15, 15);
        route(3, 2, 3, 2);
        for (int i = 0; i < 400; i++) begin
            route(int'($urandom % MX), int'($urandom % MY),
                  int'($urandom % 8), int'($urandom % 6));
        end
        done = 1'b1;
    end

    // Watchdog and final report.
    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule